// File: doc/BRIEF.md
# Serial EEPROM Read Slave

This block is the read side of a two-wire serial memory slave. It watches a synchronised SCL/SDA pair for start and stop conditions and compares each address byte against a fixed device-type nibble and a strap-selected device number. It answers three kinds of read. A current-address read uses a persistent 16-bit address counter. A random read first uses a dummy write to load a two-byte word address and then a repeated start with the read bit set. A sequential read keeps streaming bytes while the master acknowledges.

SDA is modelled as open drain. `sda_in` is the resolved bus level, and `sda_oe` high pulls the line low. The storage sits outside the block: `mem_addr` always shows the address counter, and `mem_rdata` must return the byte at that address in the same cycle. A byte is loaded into the transmit shifter on the SCL falling edge that opens its first bit.

The sequencer states are:
- `ST_IDLE`: bus free.
- `ST_DEVADDR`: receiving the address byte.
- `ST_DEV_ACK`: acknowledging the address byte.
- `ST_WADDR_HI` / `ST_HI_ACK`: receiving and acknowledging the high word address byte.
- `ST_WADDR_LO` / `ST_LO_ACK`: receiving and acknowledging the low word address byte.
- `ST_TX`: shifting out a data byte.
- `ST_MACK`: sampling the master's acknowledge.
- `ST_WAIT`: ignoring the bus until the next start or stop.

The transitions are:
- Any state goes to `ST_IDLE` on stop.
- Any state goes to `ST_DEVADDR` on start.
- `ST_DEVADDR` goes to `ST_DEV_ACK` on a match, or to `ST_WAIT` on a mismatch.
- `ST_DEV_ACK` goes to `ST_TX` when the R/W bit is 1, or to `ST_WADDR_HI` when it is 0.
- `ST_WADDR_HI` goes to `ST_HI_ACK`, then to `ST_WADDR_LO`, then to `ST_LO_ACK`, then to `ST_WAIT`.
- `ST_TX` goes to `ST_MACK` after eight bits.
- `ST_MACK` goes to `ST_TX` on an acknowledge, or to `ST_WAIT` on a not-acknowledge.

Top module: `eeprom_rd_slave`

## Requirements
- R1: After reset, and on every stop condition (SDA rising while SCL is high), the sequencer returns to idle with `sda_oe` low.
- R2: An address byte is acknowledged (SDA held low on its ninth clock) only when bits 7:4 equal 1101 and bits 3:1 equal `DEV_SEL`. Bit 0 is the R/W bit, with 1 selecting a read.
- R3: A non-matching address byte is not acknowledged. SDA stays released on every following clock until the next start, and the address counter keeps its value.
- R4: A current-address read returns the byte at the address counter, most significant bit first.
- R5: A write-direction address byte followed by two word address bytes (high byte first, each acknowledged) loads the counter with {high, low}. A repeated start with a read address byte then returns the byte at that address.
- R6: When the master acknowledges a data byte, the next byte follows at counter+1. The counter wraps from `MEM_DEPTH-1` to 0.
- R7: After each transmitted byte the counter holds that byte's address plus one. It persists across stop so that the next current-address read continues from there.
- R8: A stop issued during the ninth clock of a data byte ends the read, even if SDA was low at that clock's rising edge. No further byte is driven.
- R9: `sda_oe` changes only while SCL is low.
- R10: A start condition in the middle of a byte aborts it and returns to address matching. A word address that was only partly received is not loaded.
- R11: SDA is released (`sda_oe` low) during the ninth clock of every data byte, so the master's ACK/NACK is seen on the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Serial clock from the master |
| sda_in | input | 1 | Resolved level of the open-drain data line |
| sda_oe | output | 1 | High pulls the data line low |
| mem_addr | output | ADDR_W | Address counter, the memory read address |
| mem_rdata | input | 8 | Byte stored at `mem_addr`, same cycle |

## Verification
Two events can land on the same ninth clock of a data byte: the master's acknowledge sample, which would request the next byte, and a stop condition, which must end the read. The bench drives SDA low across the rising edge of that ninth clock and then raises SDA while SCL is still high. It judges the result by requiring the bus to stay released for a following byte's worth of clocks, and by requiring that the next current-address read returns the address just after the last byte sent. The bench also aborts a word address halfway with a repeated start, which competes with the counter load.

// File: rtl/eeprom_rd_pkg.sv
package eeprom_rd_pkg;

    // device-type nibble that leads every address byte
    localparam logic [3:0] DEV_TYPE = 4'b1101;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEVADDR,
        ST_DEV_ACK,
        ST_WADDR_HI,
        ST_HI_ACK,
        ST_WADDR_LO,
        ST_LO_ACK,
        ST_TX,
        ST_MACK,
        ST_WAIT
    } rd_state_e;

endpackage

// File: rtl/i2c_cond_det.sv
module i2c_cond_det #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [SYNC_STAGES-1:0] scl_sync;
    logic [SYNC_STAGES-1:0] sda_sync;
    logic                   scl_p;
    logic                   sda_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sync <= '1;
            sda_sync <= '1;
            scl_p    <= 1'b1;
            sda_p    <= 1'b1;
        end else begin
            scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_in};
            sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_in};
            scl_p    <= scl_sync[SYNC_STAGES-1];
            sda_p    <= sda_sync[SYNC_STAGES-1];
        end
    end

    assign scl_s     = scl_sync[SYNC_STAGES-1];
    assign sda_s     = sda_sync[SYNC_STAGES-1];
    assign scl_rise  = scl_s & ~scl_p;
    assign scl_fall  = ~scl_s & scl_p;
    // data edges while the clock stays high mark bus conditions
    assign start_det = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/rd_addr_ctr.sv
module rd_addr_ctr #(
    parameter int ADDR_W    = 16,
    parameter int MEM_DEPTH = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              inc,
    output logic [ADDR_W-1:0] addr
);

    localparam logic [ADDR_W-1:0] TOP_ADDR = ADDR_W'(MEM_DEPTH - 1);

    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (load) begin
            addr_q <= load_val;
        end else if (inc) begin
            if (addr_q == TOP_ADDR) addr_q <= '0;
            else                    addr_q <= addr_q + ADDR_W'(1);
        end
    end

    assign addr = addr_q;

endmodule

// File: rtl/rd_slave_fsm.sv
module rd_slave_fsm
    import eeprom_rd_pkg::*;
#(
    parameter int         ADDR_W  = 16,
    parameter logic [2:0] DEV_SEL = 3'b010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [7:0]        mem_rdata,
    output logic              sda_oe,
    output logic              ctr_load,
    output logic [ADDR_W-1:0] ctr_load_val,
    output logic              ctr_inc,
    output rd_state_e         state,
    output logic [7:0]        rx_byte
);

    rd_state_e  state_q, state_d;
    logic [2:0] cnt_q;
    logic [7:0] rx_q;
    logic [7:0] tx_q;
    logic [7:0] hi_q;
    logic       full_q;
    logic       mack_q;
    logic       dev_match;
    logic       bus_cond;

    assign dev_match = (rx_q[7:4] == DEV_TYPE) && (rx_q[3:1] == DEV_SEL);
    assign bus_cond  = start_det | stop_det;

    // next-state decision
    always_comb begin
        state_d = state_q;
        if (stop_det) begin
            state_d = ST_IDLE;
        end else if (start_det) begin
            state_d = ST_DEVADDR;
        end else begin
            unique case (state_q)
                ST_IDLE:     state_d = ST_IDLE;
                ST_DEVADDR:  if (scl_fall && full_q) state_d = dev_match ? ST_DEV_ACK : ST_WAIT;
                ST_DEV_ACK:  if (scl_fall) state_d = rx_q[0] ? ST_TX : ST_WADDR_HI;
                ST_WADDR_HI: if (scl_fall && full_q) state_d = ST_HI_ACK;
                ST_HI_ACK:   if (scl_fall) state_d = ST_WADDR_LO;
                ST_WADDR_LO: if (scl_fall && full_q) state_d = ST_LO_ACK;
                ST_LO_ACK:   if (scl_fall) state_d = ST_WAIT;
                ST_TX:       if (scl_fall && cnt_q == 3'd7) state_d = ST_MACK;
                ST_MACK:     if (scl_fall) state_d = mack_q ? ST_TX : ST_WAIT;
                ST_WAIT:     state_d = ST_WAIT;
                default:     state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // bit counter, shifters and captured bytes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            rx_q   <= '0;
            tx_q   <= '0;
            hi_q   <= '0;
            full_q <= 1'b0;
            mack_q <= 1'b0;
        end else if (bus_cond) begin
            cnt_q  <= '0;
            full_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_DEVADDR, ST_WADDR_HI, ST_WADDR_LO: begin
                    if (scl_rise) begin
                        rx_q  <= {rx_q[6:0], sda_s};
                        cnt_q <= cnt_q + 3'd1;
                        if (cnt_q == 3'd7) full_q <= 1'b1;
                    end
                    if (scl_fall && full_q) begin
                        full_q <= 1'b0;
                        if (state_q == ST_WADDR_HI) hi_q <= rx_q;
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (cnt_q == 3'd7) begin
                            cnt_q <= '0;
                        end else begin
                            cnt_q <= cnt_q + 3'd1;
                            tx_q  <= {tx_q[6:0], 1'b0};
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise) mack_q <= ~sda_s;
                end
                default: ;
            endcase
            if (state_d == ST_TX && state_q != ST_TX) begin
                tx_q  <= mem_rdata;
                cnt_q <= '0;
            end
        end
    end

    // outputs
    always_comb begin
        sda_oe       = 1'b0;
        ctr_load     = 1'b0;
        ctr_inc      = 1'b0;
        ctr_load_val = ADDR_W'({hi_q, rx_q});
        unique case (state_q)
            ST_DEV_ACK, ST_HI_ACK, ST_LO_ACK: sda_oe = 1'b1;
            ST_TX: begin
                sda_oe  = ~tx_q[7];
                ctr_inc = scl_fall && (cnt_q == 3'd7) && !bus_cond;
            end
            ST_WADDR_LO: ctr_load = scl_fall && full_q && !bus_cond;
            default: ;
        endcase
    end

    assign state   = state_q;
    assign rx_byte = rx_q;

endmodule

// File: rtl/eeprom_rd_slave.sv
module eeprom_rd_slave
    import eeprom_rd_pkg::*;
#(
    parameter int         ADDR_W      = 16,
    parameter int         MEM_DEPTH   = 1024,
    parameter logic [2:0] DEV_SEL     = 3'b010,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_oe,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [7:0]        mem_rdata
);

    logic              scl_s;
    logic              sda_s;
    logic              scl_rise;
    logic              scl_fall;
    logic              start_det;
    logic              stop_det;
    logic              ctr_load;
    logic              ctr_inc;
    logic [ADDR_W-1:0] ctr_load_val;
    rd_state_e         state;
    logic [7:0]        rx_byte;

    i2c_cond_det #(.SYNC_STAGES(SYNC_STAGES)) cond_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    rd_slave_fsm #(.ADDR_W(ADDR_W), .DEV_SEL(DEV_SEL)) fsm_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .sda_s        (sda_s),
        .scl_rise     (scl_rise),
        .scl_fall     (scl_fall),
        .start_det    (start_det),
        .stop_det     (stop_det),
        .mem_rdata    (mem_rdata),
        .sda_oe       (sda_oe),
        .ctr_load     (ctr_load),
        .ctr_load_val (ctr_load_val),
        .ctr_inc      (ctr_inc),
        .state        (state),
        .rx_byte      (rx_byte)
    );

    rd_addr_ctr #(.ADDR_W(ADDR_W), .MEM_DEPTH(MEM_DEPTH)) ctr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ctr_load),
        .load_val (ctr_load_val),
        .inc      (ctr_inc),
        .addr     (mem_addr)
    );

endmodule

// File: rtl/eeprom_rd_slave_chk.sv
module eeprom_rd_slave_chk
    import eeprom_rd_pkg::*;
#(
    parameter int         ADDR_W    = 16,
    parameter int         MEM_DEPTH = 1024,
    parameter logic [2:0] DEV_SEL   = 3'b010
) (
    input logic              clk,
    input logic              rst_n,
    input rd_state_e         state,
    input logic              sda_oe,
    input logic              scl_s,
    input logic              stop_det,
    input logic              ctr_inc,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [7:0]        rx_byte
);

    localparam logic [ADDR_W-1:0] TOP_ADDR = ADDR_W'(MEM_DEPTH - 1);

    a_r1_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> state == ST_IDLE);

    a_r2_ack_only_match: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_DEV_ACK |-> (rx_byte[7:4] == DEV_TYPE && rx_byte[3:1] == DEV_SEL));

    a_r6_wrap_top: assert property (@(posedge clk) disable iff (!rst_n)
        (ctr_inc && mem_addr == TOP_ADDR) |=> mem_addr == '0);

    a_r7_inc_step: assert property (@(posedge clk) disable iff (!rst_n)
        (ctr_inc && mem_addr != TOP_ADDR) |=> mem_addr == $past(mem_addr) + ADDR_W'(1));

    a_r9_drive_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_s);

    a_r11_release_mack: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_MACK |-> !sda_oe);

endmodule

bind eeprom_rd_slave eeprom_rd_slave_chk #(
    .ADDR_W    (ADDR_W),
    .MEM_DEPTH (MEM_DEPTH),
    .DEV_SEL   (DEV_SEL)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .state    (state),
    .sda_oe   (sda_oe),
    .scl_s    (scl_s),
    .stop_det (stop_det),
    .ctr_inc  (ctr_inc),
    .mem_addr (mem_addr),
    .rx_byte  (rx_byte)
);

// File: tb/eeprom_rd_slave_tb_top.sv
module eeprom_rd_slave_tb_top;

    localparam int         Q       = 10;
    localparam int         DEPTH   = 1024;
    localparam logic [7:0] DEV_WR  = 8'hD4;
    localparam logic [7:0] DEV_RD  = 8'hD5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        m_scl = 1'b1;
    logic        m_sda = 1'b1;
    logic        sda_bus;
    logic        sda_oe;
    logic [15:0] mem_addr;
    logic [7:0]  mem_rdata;

    int          n_chk = 0;
    int          n_fail = 0;
    int          r9_viol = 0;
    logic        prev_oe = 1'b0;
    logic [15:0] model_ctr = 16'h0;

    always #5 clk = ~clk;

    function automatic logic [7:0] mem_f(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction

    function automatic logic [15:0] nxt(input logic [15:0] a);
        return (a == 16'(DEPTH - 1)) ? 16'h0 : a + 16'd1;
    endfunction

    assign sda_bus   = m_sda & ~sda_oe;
    assign mem_rdata = mem_f(mem_addr);

    eeprom_rd_slave #(.MEM_DEPTH(DEPTH), .DEV_SEL(3'b010)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (m_scl),
        .sda_in    (sda_bus),
        .sda_oe    (sda_oe),
        .mem_addr  (mem_addr),
        .mem_rdata (mem_rdata)
    );

    // R9 monitor: the drive may only change while the clock line is low
    always @(negedge clk) begin
        if (rst_n && m_scl && (sda_oe !== prev_oe)) r9_viol++;
        prev_oe <= sda_oe;
    end

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wait_q();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wait_q();
        m_scl = 1'b1; wait_q();
        m_sda = 1'b0; wait_q();
        m_scl = 1'b0; wait_q();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wait_q();
        m_scl = 1'b1; wait_q();
        m_sda = 1'b1; wait_q();
    endtask

    task automatic clk_bit(input logic b, output logic seen);
        m_sda = b;    wait_q();
        m_scl = 1'b1; wait_q();
        seen  = sda_bus;
        wait_q();
        m_scl = 1'b0; wait_q();
    endtask

    task automatic write_byte(input logic [7:0] d, output logic acked);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(d[i], s);
        clk_bit(1'b1, s);
        acked = ~s;
    endtask

    task automatic read_byte(input logic mack, output logic [7:0] d, output logic ninth);
        logic s;
        d = '0;
        for (int i = 0; i < 8; i++) begin
            clk_bit(1'b1, s);
            d = {d[6:0], s};
        end
        clk_bit(~mack, ninth);
    endtask

    task automatic load_addr(input logic [15:0] a);
        logic ak;
        bus_start();
        write_byte(DEV_WR, ak);   check(ak, "R2 write address ack", int'(ak), 1);
        write_byte(a[15:8], ak);  check(ak, "R5 high word ack", int'(ak), 1);
        write_byte(a[7:0], ak);   check(ak, "R5 low word ack", int'(ak), 1);
        bus_start();
        write_byte(DEV_RD, ak);   check(ak, "R2 read address ack", int'(ak), 1);
    endtask

    // random read followed by n-1 sequential bytes
    task automatic t_seq_read(input logic [15:0] a, input int n);
        logic [7:0]  d;
        logic        nb;
        logic [15:0] e;
        e = a;
        load_addr(a);
        for (int k = 0; k < n; k++) begin
            read_byte(k < n - 1, d, nb);
            check(d == mem_f(e), (k == 0) ? "R5 random read data" : "R6 sequential data",
                  int'(d), int'(mem_f(e)));
            e = nxt(e);
        end
        check(nb == 1'b1, "R11 ninth clock released", int'(nb), 1);
        bus_stop();
        model_ctr = e;
    endtask

    task automatic t_current_read(input string tag);
        logic [7:0] d;
        logic       nb;
        logic       ak;
        bus_start();
        write_byte(DEV_RD, ak);
        check(ak, "R2 current read ack", int'(ak), 1);
        read_byte(1'b0, d, nb);
        check(d == mem_f(model_ctr), tag, int'(d), int'(mem_f(model_ctr)));
        bus_stop();
        model_ctr = nxt(model_ctr);
    endtask

    task automatic t_bad_addr(input logic [7:0] b);
        logic       ak;
        logic [7:0] d;
        logic       nb;
        bus_start();
        write_byte(b, ak);
        check(!ak, "R3 no ack on mismatch", int'(ak), 0);
        read_byte(1'b0, d, nb);
        check(d == 8'hFF && nb, "R3 bus released after mismatch", int'(d), 8'hFF);
        bus_stop();
        t_current_read("R3 counter unchanged after mismatch");
    endtask

    task automatic t_stop_ninth(input logic [15:0] a);
        logic [7:0] d;
        logic [7:0] d2;
        logic       nb;
        logic       s;
        load_addr(a);
        for (int i = 0; i < 8; i++) begin
            clk_bit(1'b1, s);
            d = {d[6:0], s};
        end
        check(d == mem_f(a), "R8 byte before stop", int'(d), int'(mem_f(a)));
        // ninth clock: acknowledge level at the rising edge, then stop while high
        m_sda = 1'b0; wait_q();
        m_scl = 1'b1; wait_q();
        m_sda = 1'b1; wait_q();
        wait_q();
        read_byte(1'b0, d2, nb);
        check(d2 == 8'hFF, "R8 no byte after stop", int'(d2), 8'hFF);
        model_ctr = nxt(a);
        t_current_read("R8 counter after stop in ninth clock");
    endtask

    task automatic t_start_abort();
        logic ak;
        logic s;
        bus_start();
        write_byte(DEV_WR, ak);
        check(ak, "R10 address ack before abort", int'(ak), 1);
        for (int i = 0; i < 4; i++) clk_bit(i[0], s);
        t_current_read("R10 partial word address not loaded");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(sda_oe == 1'b0, "R1 released after reset", int'(sda_oe), 0);

        t_seq_read(16'h0123, 1);
        t_current_read("R4 current read after random");
        t_current_read("R7 counter persists across stop");
        t_seq_read(16'h0234, 1);
        t_seq_read(16'h03FE, 3);
        t_current_read("R7 counter after wrap");
        t_bad_addr(8'hA5);
        t_bad_addr(8'hD7);
        t_stop_ninth(16'h0155);
        check(sda_oe == 1'b0, "R1 released after stop", int'(sda_oe), 0);
        t_start_abort();
        check(r9_viol == 0, "R9 drive changes only with clock low", r9_viol, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule